// File: doc/BRIEF.md
# Interline CCD Field Timing Generator

This block drives a monochrome interline-transfer CCD area sensor at 625-line, 50-field interlaced timing with field accumulation. It runs from a single clock at twice the pixel rate. Each pixel period is therefore two clock cycles, so the default 13.5 MHz clock gives a 6.75 MHz pixel rate. From that clock the block derives pixel, line and field counters. It registers every drive signal from those counters: line and field sync, a complementary pair of horizontal shift clocks, a reset-gate pulse, four-phase vertical shift clocks, a transfer-gate pulse and an overflow-drain shutter pulse. It also flags optical-black pixels, valid pixels and valid lines for the video sampling stage that follows.

Each line starts with a horizontal blanking stretch. The line sync, the vertical shift steps, the transfer gate and the shutter pulse all fall inside it. The readout stretch follows: front optical-black pixels, then active pixels, then rear optical-black pixels. The transfer gate fires on line 0 of each field. Its vertical clock pattern differs between the two fields, so each field combines a different pair of adjacent lines.

The shutter input sets the exposure as a number of lines before the next transfer. Overflow-drain pulses are issued only on lines further from that transfer than the setting. A setting of zero stops the pulses altogether, which is the full-field exposure.

Top module: `ccd_field_timing`

## Requirements
- R1: While reset is high, and until the first clock edge after it is released, hSync, vSync, hClk2, rstGate, xferGate, ofdPulse, fieldId, lineValid, pixValid and optBlack are 0, hClk1 is 1 and vClk is 4'b0011 (bit 0 is V1, bit 3 is V4).
- R2: A line is LINE_PIX pixel periods of two clocks each. During readout, hClk1 is high in the first clock of a pixel and hClk2 in the second. During blanking, hClk1 is held high and hClk2 low. The two are never high together.
- R3: rstGate pulses in the first clock of every readout pixel and stays low throughout blanking.
- R4: Horizontal blanking takes LINE_PIX-FRONT_OB-ACTIVE_PIX-REAR_OB pixels. The readout that follows is FRONT_OB front black, ACTIVE_PIX active and REAR_OB rear black pixels. optBlack is high on the black pixels, and pixValid is high on active pixels of valid lines.
- R5: Field 0 has LINES_F0 lines and field 1 has LINES_F1 lines. fieldId shows the current field and toggles at each field end. vSync is high for the first VSYNC_LINES lines of each field.
- R6: hSync is high for the first HSYNC_PIX pixels of every line.
- R7: lineValid is high on lines VBLANK_LINES to VBLANK_LINES+ACTIVE_LINES-1 of each field.
- R8: On every line except line 0, four steps of VSTEP_PIX pixels each begin at pixel VSTEP_START. The steps drive vClk to 0110, 1100, 1001 and then 0011. Outside these steps vClk rests at 0011, so exactly two phases are high at all times.
- R9: On line 0, xferGate is high over the same pixel window. V1 is high throughout, and vClk is 1001 in field 0 and 0011 in field 1.
- R10: With shutter setting S, ofdPulse is high for pixels OFD_START to OFD_START+OFD_PIX-1 on every line whose distance to the next field start (field length minus line number) exceeds S. It is never high together with xferGate.
- R11: A shutter setting of 0, or any setting at least equal to the field length, produces no ofdPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| shutterLines | input | LINE_W | Exposure setting in lines; 0 gives full-field exposure |
| hSync | output | 1 | Line sync |
| vSync | output | 1 | Field sync |
| hClk1 | output | 1 | Horizontal shift clock, phase 1 |
| hClk2 | output | 1 | Horizontal shift clock, phase 2 |
| rstGate | output | 1 | Output reset-gate pulse |
| vClk | output | 4 | Vertical shift clocks, bit 0 is V1 |
| xferGate | output | 1 | Photodiode-to-register transfer gate |
| ofdPulse | output | 1 | Overflow-drain shutter pulse |
| fieldId | output | 1 | Current field, 0 or 1 |
| lineValid | output | 1 | Current line holds active pixels |
| pixValid | output | 1 | Current pixel is active on a valid line |
| optBlack | output | 1 | Current pixel is optical black |

## Verification
Every output is one register stage past the counters, and the counters advance on every clock edge after reset is released. After edge n, the outputs therefore reflect counter state n-1, and the shutter value that counts is the one present at edge n. The bench counts edges since release and recomputes each output from the requirements for state n-1 at the falling edge that follows. It uses the shutter value it captured at that rising edge. Between release and the first edge, and through a reset asserted mid-run, the bench expects the R1 values.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  // Strobes from control to the horizontal datapath
  typedef struct packed {
    logic pixPhase;   // 0: first clock of a pixel, 1: second
    logic readWin;    // pixel counter is past horizontal blanking
  } hStrobe_t;

  // Strobes from control to the vertical datapath
  typedef struct packed {
    logic lineZero;   // first line of a field
    logic fieldId;    // current field
  } vStrobe_t;

  localparam logic [3:0] V_REST    = 4'b0011;
  localparam logic [3:0] V_XFER_F0 = 4'b1001;
  localparam logic [3:0] V_XFER_F1 = 4'b0011;

  // Pattern for each of the four vertical shift steps
  function automatic logic [3:0] vStepPat(input logic [1:0] k);
    case (k)
      2'd0:    vStepPat = 4'b0110;
      2'd1:    vStepPat = 4'b1100;
      2'd2:    vStepPat = 4'b1001;
      default: vStepPat = 4'b0011;
    endcase
  endfunction

endpackage

// File: rtl/ccd_tg_ctrl.sv
module ccd_tg_ctrl
  import ccd_tg_pkg::*;
#(
  parameter int LINE_PIX = 432,
  parameter int HBLANK   = 48,
  parameter int LINES_F0 = 313,
  parameter int LINES_F1 = 312,
  parameter int PIX_W    = 9,
  parameter int LINE_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PIX_W-1:0]  pixCnt,
  output logic [LINE_W-1:0] lineCnt,
  output hStrobe_t          hStrb,
  output vStrobe_t          vStrb
);

  localparam logic [PIX_W-1:0]  PIX_LAST = PIX_W'(LINE_PIX - 1);
  localparam logic [PIX_W-1:0]  HB_C     = PIX_W'(HBLANK);
  localparam logic [LINE_W-1:0] LAST_F0  = LINE_W'(LINES_F0 - 1);
  localparam logic [LINE_W-1:0] LAST_F1  = LINE_W'(LINES_F1 - 1);

  logic phase;
  logic field;
  logic pixEnd;
  logic lineLast;
  logic lineEnd;

  assign pixEnd   = phase && (pixCnt == PIX_LAST);
  assign lineLast = (lineCnt == (field ? LAST_F1 : LAST_F0));
  assign lineEnd  = pixEnd && lineLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      field   <= 1'b0;
      pixCnt  <= '0;
      lineCnt <= '0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (pixEnd) begin
          pixCnt <= '0;
          if (lineLast) begin
            lineCnt <= '0;
            field   <= ~field;
          end else begin
            lineCnt <= lineCnt + 1'b1;
          end
        end else begin
          pixCnt <= pixCnt + 1'b1;
        end
      end
    end
  end

  assign hStrb.pixPhase = phase;
  assign hStrb.readWin  = (pixCnt >= HB_C);
  assign vStrb.lineZero = (lineCnt == '0);
  assign vStrb.fieldId  = field;

  AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pixCnt <= PIX_LAST); // R2
  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (rst)
    lineEnd |=> (field != $past(field))); // R5
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pixEnd |=> (lineCnt == $past(lineCnt))); // R5

endmodule

// File: rtl/ccd_tg_hdp.sv
module ccd_tg_hdp
  import ccd_tg_pkg::*;
#(
  parameter int HBLANK       = 48,
  parameter int FRONT_OB     = 2,
  parameter int ACTIVE_PIX   = 362,
  parameter int HSYNC_PIX    = 8,
  parameter int VBLANK_LINES = 21,
  parameter int ACTIVE_LINES = 291,
  parameter int PIX_W        = 9,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  hStrobe_t          hStrb,
  input  logic [PIX_W-1:0]  pixCnt,
  input  logic [LINE_W-1:0] lineCnt,
  output logic              hSync,
  output logic              hClk1,
  output logic              hClk2,
  output logic              rstGate,
  output logic              lineValid,
  output logic              pixValid,
  output logic              optBlack
);

  localparam logic [PIX_W-1:0]  HS_C   = PIX_W'(HSYNC_PIX);
  localparam logic [PIX_W-1:0]  ACT_LO = PIX_W'(HBLANK + FRONT_OB);
  localparam logic [PIX_W-1:0]  ACT_HI = PIX_W'(HBLANK + FRONT_OB + ACTIVE_PIX);
  localparam logic [LINE_W-1:0] LV_LO  = LINE_W'(VBLANK_LINES);
  localparam logic [LINE_W-1:0] LV_HI  = LINE_W'(VBLANK_LINES + ACTIVE_LINES);

  logic activeCol;
  logic lineAct;

  assign activeCol = (pixCnt >= ACT_LO) && (pixCnt < ACT_HI);
  assign lineAct   = (lineCnt >= LV_LO) && (lineCnt < LV_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      hSync     <= 1'b0;
      hClk1     <= 1'b1;
      hClk2     <= 1'b0;
      rstGate   <= 1'b0;
      lineValid <= 1'b0;
      pixValid  <= 1'b0;
      optBlack  <= 1'b0;
    end else begin
      hSync     <= (pixCnt < HS_C);
      hClk1     <= !hStrb.readWin || !hStrb.pixPhase;
      hClk2     <= hStrb.readWin && hStrb.pixPhase;
      rstGate   <= hStrb.readWin && !hStrb.pixPhase;
      lineValid <= lineAct;
      pixValid  <= lineAct && activeCol;
      optBlack  <= hStrb.readWin && !activeCol;
    end
  end

  AST_HCLK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hClk1 && hClk2)); // R2
  AST_RG_FIRST_HALF: assert property (@(posedge clk) disable iff (rst)
    rstGate |-> hClk1); // R3
  AST_VALID_LINE: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> lineValid); // R7
  AST_OB_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    optBlack |-> !pixValid); // R4

endmodule

// File: rtl/ccd_tg_vdp.sv
module ccd_tg_vdp
  import ccd_tg_pkg::*;
#(
  parameter int VSTEP_START = 8,
  parameter int VSTEP_PIX   = 6,
  parameter int OFD_START   = 34,
  parameter int OFD_PIX     = 8,
  parameter int LINES_F0    = 313,
  parameter int LINES_F1    = 312,
  parameter int VSYNC_LINES = 3,
  parameter int PIX_W       = 9,
  parameter int LINE_W      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  vStrobe_t          vStrb,
  input  logic [PIX_W-1:0]  pixCnt,
  input  logic [LINE_W-1:0] lineCnt,
  input  logic [LINE_W-1:0] shutterLines,
  output logic              vSync,
  output logic [3:0]        vClk,
  output logic              xferGate,
  output logic              ofdPulse,
  output logic              fieldId
);

  localparam logic [PIX_W-1:0]  VS_C    = PIX_W'(VSTEP_START);
  localparam logic [PIX_W-1:0]  VE_C    = PIX_W'(VSTEP_START + 4 * VSTEP_PIX);
  localparam logic [PIX_W-1:0]  VSTEP_C = PIX_W'(VSTEP_PIX);
  localparam logic [PIX_W-1:0]  OS_C    = PIX_W'(OFD_START);
  localparam logic [PIX_W-1:0]  OE_C    = PIX_W'(OFD_START + OFD_PIX);
  localparam logic [LINE_W-1:0] VSYNC_C = LINE_W'(VSYNC_LINES);
  localparam logic [LINE_W:0]   LEN0_C  = (LINE_W + 1)'(LINES_F0);
  localparam logic [LINE_W:0]   LEN1_C  = (LINE_W + 1)'(LINES_F1);

  logic             vWin;
  logic [PIX_W-1:0] offs;
  logic [1:0]       step;
  logic [LINE_W:0]  toGo;
  logic             ofdOn;
  logic [3:0]       vNext;

  assign vWin  = (pixCnt >= VS_C) && (pixCnt < VE_C);
  assign offs  = pixCnt - VS_C;
  assign step  = 2'(offs / VSTEP_C);
  assign toGo  = (vStrb.fieldId ? LEN1_C : LEN0_C) - {1'b0, lineCnt};
  assign ofdOn = (shutterLines != '0) && (toGo > {1'b0, shutterLines})
               && (pixCnt >= OS_C) && (pixCnt < OE_C);

  always_comb begin
    if (vWin && vStrb.lineZero)
      vNext = vStrb.fieldId ? V_XFER_F1 : V_XFER_F0;
    else if (vWin)
      vNext = vStepPat(step);
    else
      vNext = V_REST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vSync    <= 1'b0;
      vClk     <= V_REST;
      xferGate <= 1'b0;
      ofdPulse <= 1'b0;
      fieldId  <= 1'b0;
    end else begin
      vSync    <= (lineCnt < VSYNC_C);
      vClk     <= vNext;
      xferGate <= vWin && vStrb.lineZero;
      ofdPulse <= ofdOn;
      fieldId  <= vStrb.fieldId;
    end
  end

  AST_VCLK_TWO_HIGH: assert property (@(posedge clk) disable iff (rst)
    $countones(vClk) == 2); // R8
  AST_TG_HOLDS_V1: assert property (@(posedge clk) disable iff (rst)
    xferGate |-> vClk[0]); // R9
  AST_TG_NO_OFD: assert property (@(posedge clk) disable iff (rst)
    !(xferGate && ofdPulse)); // R10
  AST_OFD_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    ($past(shutterLines) == '0) |-> !ofdPulse); // R11

endmodule

// File: rtl/ccd_field_timing.sv
module ccd_field_timing
  import ccd_tg_pkg::*;
#(
  parameter int LINE_PIX     = 432,
  parameter int FRONT_OB     = 2,
  parameter int ACTIVE_PIX   = 362,
  parameter int REAR_OB      = 20,
  parameter int HSYNC_PIX    = 8,
  parameter int VSTEP_START  = 8,
  parameter int VSTEP_PIX    = 6,
  parameter int OFD_START    = 34,
  parameter int OFD_PIX      = 8,
  parameter int LINES_F0     = 313,
  parameter int LINES_F1     = 312,
  parameter int VBLANK_LINES = 21,
  parameter int ACTIVE_LINES = 291,
  parameter int VSYNC_LINES  = 3,
  localparam int PIX_W  = $clog2(LINE_PIX),
  localparam int LINE_W = $clog2(((LINES_F0 > LINES_F1) ? LINES_F0 : LINES_F1) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] shutterLines,
  output logic              hSync,
  output logic              vSync,
  output logic              hClk1,
  output logic              hClk2,
  output logic              rstGate,
  output logic [3:0]        vClk,
  output logic              xferGate,
  output logic              ofdPulse,
  output logic              fieldId,
  output logic              lineValid,
  output logic              pixValid,
  output logic              optBlack
);

  localparam int HBLANK = LINE_PIX - FRONT_OB - ACTIVE_PIX - REAR_OB;

  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  hStrobe_t          hStrb;
  vStrobe_t          vStrb;

  ccd_tg_ctrl #(
    .LINE_PIX(LINE_PIX), .HBLANK(HBLANK), .LINES_F0(LINES_F0),
    .LINES_F1(LINES_F1), .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pixCnt(pixCnt), .lineCnt(lineCnt),
    .hStrb(hStrb), .vStrb(vStrb)
  );

  ccd_tg_hdp #(
    .HBLANK(HBLANK), .FRONT_OB(FRONT_OB), .ACTIVE_PIX(ACTIVE_PIX),
    .HSYNC_PIX(HSYNC_PIX), .VBLANK_LINES(VBLANK_LINES),
    .ACTIVE_LINES(ACTIVE_LINES), .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_hdp (
    .clk(clk), .rst(rst), .hStrb(hStrb), .pixCnt(pixCnt), .lineCnt(lineCnt),
    .hSync(hSync), .hClk1(hClk1), .hClk2(hClk2), .rstGate(rstGate),
    .lineValid(lineValid), .pixValid(pixValid), .optBlack(optBlack)
  );

  ccd_tg_vdp #(
    .VSTEP_START(VSTEP_START), .VSTEP_PIX(VSTEP_PIX), .OFD_START(OFD_START),
    .OFD_PIX(OFD_PIX), .LINES_F0(LINES_F0), .LINES_F1(LINES_F1),
    .VSYNC_LINES(VSYNC_LINES), .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_vdp (
    .clk(clk), .rst(rst), .vStrb(vStrb), .pixCnt(pixCnt), .lineCnt(lineCnt),
    .shutterLines(shutterLines), .vSync(vSync), .vClk(vClk),
    .xferGate(xferGate), .ofdPulse(ofdPulse), .fieldId(fieldId)
  );

endmodule

// File: tb/ccd_field_timing_bench.sv
module ccd_field_timing_bench;

  localparam int LP  = 40;
  localparam int FOB = 2;
  localparam int ACT = 10;
  localparam int ROB = 4;
  localparam int HS  = 2;
  localparam int VST = 2;
  localparam int VSP = 2;
  localparam int OS  = 12;
  localparam int OP  = 4;
  localparam int L0  = 9;
  localparam int L1  = 8;
  localparam int VB  = 3;
  localparam int AL  = 5;
  localparam int VS  = 1;
  localparam int SW  = 4;
  localparam int FRAME_CYC = 2 * LP * (L0 + L1);
  localparam logic [14:0] RST_VEC = 15'b0_0_1_0_0_0011_0_0_0_0_0_0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] shutter = '0;
  logic [SW-1:0] shLast = '0;
  logic          hSync, vSync, hClk1, hClk2, rstGate, xferGate, ofdPulse;
  logic          fieldId, lineValid, pixValid, optBlack;
  logic [3:0]    vClk;
  int            k = 0;
  int            nChk = 0;
  int            nFail = 0;
  bit            chkOn = 1'b0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  ccd_field_timing #(
    .LINE_PIX(LP), .FRONT_OB(FOB), .ACTIVE_PIX(ACT), .REAR_OB(ROB),
    .HSYNC_PIX(HS), .VSTEP_START(VST), .VSTEP_PIX(VSP), .OFD_START(OS),
    .OFD_PIX(OP), .LINES_F0(L0), .LINES_F1(L1), .VBLANK_LINES(VB),
    .ACTIVE_LINES(AL), .VSYNC_LINES(VS)
  ) u_ccd_field_timing (
    .clk(clk), .rst(rst), .shutterLines(shutter), .hSync(hSync),
    .vSync(vSync), .hClk1(hClk1), .hClk2(hClk2), .rstGate(rstGate),
    .vClk(vClk), .xferGate(xferGate), .ofdPulse(ofdPulse),
    .fieldId(fieldId), .lineValid(lineValid), .pixValid(pixValid),
    .optBlack(optBlack)
  );

  // Edges since reset release, and shutter value seen at each edge
  always @(posedge clk) begin
    k      <= rst ? 0 : k + 1;
    shLast <= shutter;
  end

  // Expected outputs for counter state s, from the requirements
  function automatic logic [14:0] expOut(input int s, input int sh);
    int ph, pt, pix, lf, line, fld, flen, hb;
    bit inRead, vwin, lv, act;
    logic [3:0] v;
    logic [14:0] e;
    ph = s % 2;
    pt = s / 2;
    pix = pt % LP;
    lf = (pt / LP) % (L0 + L1);
    if (lf < L0) begin fld = 0; line = lf; flen = L0; end
    else begin fld = 1; line = lf - L0; flen = L1; end
    hb = LP - FOB - ACT - ROB;
    inRead = (pix >= hb);
    vwin = (pix >= VST) && (pix < VST + 4 * VSP);
    if (vwin && line == 0) v = (fld == 1) ? 4'b0011 : 4'b1001;
    else if (vwin) begin
      case ((pix - VST) / VSP)
        0: v = 4'b0110;
        1: v = 4'b1100;
        2: v = 4'b1001;
        default: v = 4'b0011;
      endcase
    end else v = 4'b0011;
    lv  = (line >= VB) && (line < VB + AL);
    act = (pix >= hb + FOB) && (pix < hb + FOB + ACT);
    e[14]  = (pix < HS);
    e[13]  = (line < VS);
    e[12]  = !inRead || (ph == 0);
    e[11]  = inRead && (ph == 1);
    e[10]  = inRead && (ph == 0);
    e[9:6] = v;
    e[5]   = vwin && (line == 0);
    e[4]   = (sh != 0) && ((flen - line) > sh) && (pix >= OS) && (pix < OS + OP);
    e[3]   = (fld == 1);
    e[2]   = lv;
    e[1]   = lv && act;
    e[0]   = inRead && !act;
    return e;
  endfunction

  task automatic chk(input string req, input string nm,
                     input logic [3:0] act, input logic [3:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", req, nm, act, exp, k);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      logic [14:0] e;
      bit rs;
      rs = (k == 0);
      e = rs ? RST_VEC : expOut(k - 1, int'(shLast));
      chk(rs ? "R1" : "R6", "hSync",   {3'b0, hSync},     {3'b0, e[14]});
      chk(rs ? "R1" : "R5", "vSync",   {3'b0, vSync},     {3'b0, e[13]});
      chk(rs ? "R1" : "R2", "hClk1",   {3'b0, hClk1},     {3'b0, e[12]});
      chk(rs ? "R1" : "R2", "hClk2",   {3'b0, hClk2},     {3'b0, e[11]});
      chk(rs ? "R1" : "R3", "rstGate", {3'b0, rstGate},   {3'b0, e[10]});
      chk(rs ? "R1" : (e[5] ? "R9" : "R8"), "vClk", vClk, e[9:6]);
      chk(rs ? "R1" : "R9", "xferGate", {3'b0, xferGate}, {3'b0, e[5]});
      chk(rs ? "R1" : ((shLast == 0 || int'(shLast) >= L1) ? "R11" : "R10"),
          "ofdPulse", {3'b0, ofdPulse}, {3'b0, e[4]});
      chk(rs ? "R1" : "R5", "fieldId",   {3'b0, fieldId},   {3'b0, e[3]});
      chk(rs ? "R1" : "R7", "lineValid", {3'b0, lineValid}, {3'b0, e[2]});
      chk(rs ? "R1" : "R4", "pixValid",  {3'b0, pixValid},  {3'b0, e[1]});
      chk(rs ? "R1" : "R4", "optBlack",  {3'b0, optBlack},  {3'b0, e[0]});
    end
  end

  task automatic runWith(input logic [SW-1:0] sh);
    shutter = sh;
    repeat (2 * FRAME_CYC) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    chkOn = 1'b1;                 // R1 checked while reset is held
    repeat (3) @(negedge clk);
    rst = 1'b0;
    runWith(4'd0);                // R11: zero disables shutter pulses
    runWith(4'd3);                // R10: short exposure
    runWith(4'd9);                // R11: setting not below field length
    runWith(4'd1);                // R10: shortest exposure
    rst = 1'b1;                   // R1: reset in mid-field
    repeat (3) @(negedge clk);
    rst = 1'b0;
    runWith(4'd15);
    for (int i = 0; i < 3; i++) runWith(SW'($urandom % 16));
    chkOn = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule